// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a clock-recovery loop has reached the right frequency. A divided copy of the oscillator arrives asynchronously. It is synchronized into the reference clock domain, and its rising edges are counted over a fixed window of reference cycles. When each window closes, the count is compared with an expected value. A two-state controller moves between frequency acquisition and phase acquisition. Lock is granted only when the count is inside a narrow band. Once held, lock is kept until the count leaves a wider band. This hysteresis stops the lock flag from chattering near the threshold.

The block drives a lock flag and a standard-detect flag. It also handles a 3-bit rate code. In auto mode the block drives the code and remembers the last rate it locked to. In manual mode the block does not drive the code; it reads it from outside, and lock can only be granted when the code selects the supported rate. Every counter and timer runs on the reference clock.

Top module: `freq_lock_det`

## Requirements
- R1: After reset the controller is in frequency acquisition, `locked` and `std_det` are 0, and `rate_out` is 000.
- R2: The controller changes state only on the last cycle of each window of `WIN_CYC` reference cycles, counted from reset release. `locked` therefore changes only at window boundaries.
- R3: `vco_div` passes through a two-flop synchronizer. Each rising edge is counted exactly once, in the window where it is detected.
- R4: In frequency acquisition, a window count within ±`TOL_ACQ` of `EXP_CNT` (default 100 ± 1) moves the controller to phase acquisition and sets `locked`. A count that differs by more than that leaves it unlocked.
- R5: In phase acquisition, lock is kept while the count stays within ±`TOL_HOLD` (default ±2). A count outside that band returns the controller to frequency acquisition and clears `locked`.
- R6: `std_det` is 1 exactly when `locked` is 1 and the stored rate code is `RATE_CODE` (default 010).
- R7: In auto mode (`auto_mode`=1), `rate_oe` is 1. On each lock `rate_out` takes 010, and it keeps that value after lock is lost.
- R8: In manual mode (`auto_mode`=0), `rate_oe` is 0. Lock is granted only if `rate_in` equals 010. If `rate_in` differs while locked, lock is dropped at the next window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; it clocks all timers and counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| vco_div | input | 1 | Divided oscillator signal, asynchronous |
| auto_mode | input | 1 | 1 = automatic rate detection, 0 = manual rate select |
| rate_in | input | 3 | Rate code read from the pins in manual mode |
| locked | output | 1 | High while in phase acquisition |
| std_det | output | 1 | High when locked to the supported standard rate |
| rate_out | output | 3 | Last locked rate code |
| rate_oe | output | 1 | Drive enable for the rate code pins (high in auto mode) |

## Verification
The assertions assume that `vco_div` pulses last at least one reference cycle high and one low, so the window count can never exceed the window length. They also assume that `rate_in` and `auto_mode` are quasi-static and change only at a clock edge. The bench drives every input at the falling edge and sends each window's pulses as a burst of one-cycle-high, one-cycle-low pulses. Each burst is placed well inside the window, so the synchronizer delay never moves an edge into a neighbouring window. Because of this, every expected window count is exact.

// File: rtl/freq_lock_det.sv
module freq_lock_det #(
  parameter int WIN_CYC  = 400,
  parameter int EXP_CNT  = 100,
  parameter int TOL_ACQ  = 1,
  parameter int TOL_HOLD = 2,
  parameter logic [2:0] RATE_CODE = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vco_div,
  input  logic       auto_mode,
  input  logic [2:0] rate_in,
  output logic       locked,
  output logic       std_det,
  output logic [2:0] rate_out,
  output logic       rate_oe
);
  localparam int WW = $clog2(WIN_CYC);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_CYC - 1);
  localparam logic [CW:0]   EXP      = (CW+1)'(EXP_CNT);
  localparam logic [CW:0]   TA       = (CW+1)'(TOL_ACQ);
  localparam logic [CW:0]   TH       = (CW+1)'(TOL_HOLD);

  typedef enum logic {FREQ_ACQ, PHASE_ACQ} acq_t;

  acq_t          state;
  logic [2:0]    vsync;
  logic [WW-1:0] win_cnt;
  logic [CW-1:0] edge_cnt;
  logic [2:0]    last_rate;
  logic          rise, win_end, rate_ok;
  logic [CW:0]   total, diff;

  assign rise    = vsync[1] & ~vsync[2];
  assign win_end = (win_cnt == WIN_LAST);
  assign total   = {1'b0, edge_cnt} + {{CW{1'b0}}, rise};
  assign diff    = (total >= EXP) ? total - EXP : EXP - total;
  assign rate_ok = auto_mode | (rate_in == RATE_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsync    <= '0;
      win_cnt  <= '0;
      edge_cnt <= '0;
    end else begin
      vsync    <= {vsync[1:0], vco_div};
      win_cnt  <= win_end ? '0 : win_cnt + 1'b1;
      edge_cnt <= win_end ? '0 : total[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FREQ_ACQ;
      last_rate <= 3'b000;
    end else if (win_end) begin
      if (state == FREQ_ACQ && diff <= TA && rate_ok) begin
        state     <= PHASE_ACQ;
        last_rate <= RATE_CODE;
      end else if (state == PHASE_ACQ && (diff > TH || !rate_ok)) begin
        state <= FREQ_ACQ;
      end
    end
  end

  assign locked   = (state == PHASE_ACQ);
  assign std_det  = locked && (last_rate == RATE_CODE);
  assign rate_out = last_rate;
  assign rate_oe  = auto_mode;
endmodule

module freq_lock_det_chk #(
  parameter int WIN_CYC = 400,
  parameter logic [2:0] RATE_CODE = 3'b010,
  localparam int WW = $clog2(WIN_CYC),
  localparam int CW = $clog2(WIN_CYC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          locked,
  input logic          std_det,
  input logic [2:0]    rate_out,
  input logic          auto_mode,
  input logic [2:0]    rate_in,
  input logic [WW-1:0] win_cnt,
  input logic [CW-1:0] edge_cnt
);
  a_r2_change_at_window_end: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> ($past(win_cnt) == WW'(WIN_CYC - 1)));
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= CW'(WIN_CYC));
  a_r6_std_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    std_det |-> locked);
  a_r7_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(locked) |-> $stable(rate_out));
  a_r8_manual_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(auto_mode) || $past(rate_in) == RATE_CODE));
endmodule

bind freq_lock_det freq_lock_det_chk #(.WIN_CYC(WIN_CYC), .RATE_CODE(RATE_CODE)) chk_i (
  .clk(clk), .rst_n(rst_n), .locked(locked), .std_det(std_det), .rate_out(rate_out),
  .auto_mode(auto_mode), .rate_in(rate_in), .win_cnt(win_cnt), .edge_cnt(edge_cnt)
);

// File: tb/freq_lock_det_tb_top.sv
module freq_lock_det_tb_top;
  localparam int WIN = 400;
  logic clk = 1'b0, rst_n = 1'b0, vco_div = 1'b0, auto_mode = 1'b1;
  logic [2:0] rate_in = 3'b000;
  logic locked, std_det, rate_oe;
  logic [2:0] rate_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  freq_lock_det dut_i (.clk(clk), .rst_n(rst_n), .vco_div(vco_div), .auto_mode(auto_mode),
    .rate_in(rate_in), .locked(locked), .std_det(std_det), .rate_out(rate_out), .rate_oe(rate_oe));

  // {auto, rate_in[2:0], edges[7:0], exp_locked, exp_std, exp_rate[2:0]}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 3'b000, 8'd102, 1'b0, 1'b0, 3'b000},  // R4 102 too far to acquire
    {1'b1, 3'b000, 8'd99,  1'b1, 1'b1, 3'b010},  // R4 acquire at -1
    {1'b1, 3'b000, 8'd102, 1'b1, 1'b1, 3'b010},  // R5 hold at +2
    {1'b1, 3'b000, 8'd98,  1'b1, 1'b1, 3'b010},  // R5 hold at -2
    {1'b1, 3'b000, 8'd103, 1'b0, 1'b0, 3'b010},  // R5 drop at +3, R7 retained
    {1'b1, 3'b000, 8'd101, 1'b1, 1'b1, 3'b010},  // R4 acquire at +1
    {1'b1, 3'b000, 8'd97,  1'b0, 1'b0, 3'b010},  // R5 drop at -3
    {1'b1, 3'b000, 8'd0,   1'b0, 1'b0, 3'b010},  // R3 no edges
    {1'b0, 3'b011, 8'd100, 1'b0, 1'b0, 3'b010},  // R8 wrong rate blocks lock
    {1'b0, 3'b010, 8'd100, 1'b1, 1'b1, 3'b010},  // R8 selected rate locks
    {1'b0, 3'b010, 8'd102, 1'b1, 1'b1, 3'b010},  // R8 manual hold
    {1'b0, 3'b011, 8'd100, 1'b0, 1'b0, 3'b010}   // R8 mismatch drops lock
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_window(input int n);
    for (int k = 0; k < WIN; k++) begin
      vco_div = (k >= 50 && k < 50 + 2 * n && ((k - 50) % 2 == 0));
      @(posedge clk); @(negedge clk);
    end
    vco_div = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 locked", locked, 0);
    check("R1 std_det", std_det, 0);
    check("R1 rate_out", rate_out, 3'b000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      auto_mode = VEC[i][16];
      rate_in   = VEC[i][15:13];
      run_window(int'(VEC[i][12:5]));
      check($sformatf("R4/R5/R8 vec%0d locked", i), locked, VEC[i][4]);
      check($sformatf("R6 vec%0d std_det", i), std_det, VEC[i][3]);
      check($sformatf("R7 vec%0d rate_out", i), rate_out, VEC[i][2:0]);
      check($sformatf("R7/R8 vec%0d rate_oe", i), rate_oe, VEC[i][16]);
    end
    // R2: lock appears only at the window boundary
    auto_mode = 1'b1;
    for (int k = 0; k < WIN; k++) begin
      vco_div = (k >= 50 && k < 250 && ((k - 50) % 2 == 0));
      @(posedge clk); @(negedge clk);
      if (k == WIN - 2) check("R2 not locked before window end", locked, 0);
    end
    vco_div = 1'b0;
    check("R2 locked at window end", locked, 1);
    // R1: reset mid-lock
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears lock", locked, 0);
    check("R1 reset clears rate", rate_out, 3'b000);
    check("R1 reset clears std", std_det, 0);
    rst_n = 1'b1;
    run_window(100);
    check("R3 exact count relocks", locked, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule